// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the control unit of an unpipelined integer processor. Each instruction moves through a fixed run of phases, one per clock: fetch, decode with register read, execute or address calculation, memory access, and write-back. The sequencer is in exactly one phase at a time. It raises the strobes that a datapath needs in that phase, and it returns to fetch once the instruction's last phase is done. It holds the program counter and the instruction register. The ALU, the register file and both memories live outside the block and see only its strobes.

An external decoder presents the instruction class during decode, along with the result of the register equality compare. The sequencer latches the class at the end of decode. Branches end after decode, stores after the memory phase, and every other class after write-back. A taken branch loads the PC with the incremented PC plus the sign-extended offset scaled by four. A one-cycle done pulse marks the final phase of each instruction, so cycles per instruction can be counted from the outside.

Top module: `mseq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in fetch with `pc_o` equal to 0, even in the middle of an instruction. Fetch, decode, execute, memory and write-back show as `phase_o` bits 0, 1, 2, 3 and 4.
- R2: `phase_o` has exactly one bit set in every cycle.
- R3: In fetch, `pc_we_o` is 1 and `pc_sel_o` is 0, and the PC advances by 4 at the end of the cycle. `instr_i` is captured into `ir_o` at that edge, and later changes of `instr_i` do not alter `ir_o`.
- R4: Class code 4 (branch) takes 2 cycles. If `cmp_eq_i` is 1 in decode, `pc_we_o` and `pc_sel_o` are both 1, and the PC becomes the incremented PC plus `ir_o[15:0]` sign-extended and multiplied by 4. Otherwise the PC keeps the incremented value.
- R5: Class code 3 (store) takes 4 cycles, with `mem_wr_o` high only in its memory phase.
- R6: Class code 2 (load) takes 5 cycles, with `mem_rd_o` high in the memory phase and `rf_we_o` high in write-back.
- R7: Class codes 0 and 1 (ALU register and ALU immediate) take 5 cycles, raise no memory strobe and raise `rf_we_o` in write-back. Unassigned codes 5 to 7 behave like code 0.
- R8: `done_o` is high for exactly the last cycle of each instruction, and the next cycle is fetch.
- R9: The class is sampled only during decode. Changes of `cls_i` or `cmp_eq_i` in later phases do not affect the phase count or the strobes.
- R10: `mem_rd_o` and `mem_wr_o` are never high together, and neither is high outside the memory phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word read at `pc_o` during fetch |
| cls_i | input | 3 | Decoded instruction class, used during decode |
| cmp_eq_i | input | 1 | Register equality compare result, used during decode |
| pc_o | output | 32 | Program counter |
| ir_o | output | 32 | Latched instruction word |
| phase_o | output | 5 | One-hot current phase |
| pc_we_o | output | 1 | PC load enable |
| pc_sel_o | output | 1 | PC source: 0 sequential, 1 branch target |
| rf_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| done_o | output | 1 | Final cycle of the current instruction |

## Verification
The assertions check the invariants that hold in every cycle:
- `phase_o` stays one-hot.
- The PC grows by 4 after each fetch.
- Memory strobes appear only in the memory phase and never both at once.
- Register writes and taken-branch PC loads fall in an instruction's final cycle.
- Done is always followed by fetch.

Other behaviours can only be shown by the bench's scenarios:
- The per-class cycle counts.
- The exact branch target for positive, negative and extreme offsets.
- The fallback for unassigned codes.
- Immunity to class changes after decode.
- Reset in the middle of an instruction.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned NPH     = 5;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned STEP    = INSTR_W / 8;
  localparam int unsigned SCALE_SH = 2;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEMORY = 3'd3,
    PH_WRBACK = 3'd4
  } phase_e;

  typedef enum logic [CODE_W-1:0] {
    K_ALU_RR = 3'd0,
    K_ALU_RI = 3'd1,
    K_LOAD   = 3'd2,
    K_STORE  = 3'd3,
    K_BRANCH = 3'd4
  } kind_e;

  function automatic kind_e kind_of(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    return K_ALU_RI;
      3'd2:    return K_LOAD;
      3'd3:    return K_STORE;
      3'd4:    return K_BRANCH;
      default: return K_ALU_RR;
    endcase
  endfunction

  function automatic phase_e final_phase(input kind_e k);
    case (k)
      K_BRANCH: return PH_DECODE;
      K_STORE:  return PH_MEMORY;
      default:  return PH_WRBACK;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(STEP);
  endfunction

  function automatic logic [ADDR_W-1:0] branch_dest(input logic [ADDR_W-1:0] pc_inc,
                                                    input logic [OFF_W-1:0]  off);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
    return pc_inc + (ext << SCALE_SH);
  endfunction

  function automatic logic writes_reg(input kind_e k);
    return (k != K_STORE) && (k != K_BRANCH);
  endfunction
endpackage

// File: rtl/mseq_phase_fsm.sv
module mseq_phase_fsm
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output phase_e            phase_o,
  output kind_e             kind_eff_o,
  output logic              last_o
);
  phase_e ph_q;
  phase_e ph_d;
  kind_e  kind_q;
  kind_e  kind_live;
  kind_e  kind_eff;
  logic   last;

  assign kind_live = kind_of(code_i);
  assign kind_eff  = (ph_q == PH_DECODE) ? kind_live : kind_q;
  assign last      = (ph_q == final_phase(kind_eff));
  assign ph_d      = last ? PH_FETCH : phase_e'(ph_q + 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_FETCH;
      kind_q <= K_ALU_RR;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_DECODE) kind_q <= kind_live;
    end
  end

  assign phase_o    = ph_q;
  assign kind_eff_o = kind_eff;
  assign last_o     = last;
endmodule

// File: rtl/mseq_strobes.sv
module mseq_strobes
  import mseq_pkg::*;
(
  input  phase_e         phase_i,
  input  kind_e          kind_i,
  input  logic           cmp_eq_i,
  output logic [NPH-1:0] onehot_o,
  output logic           pc_we_o,
  output logic           pc_sel_o,
  output logic           ir_we_o,
  output logic           rf_we_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           br_taken_o
);
  for (genvar g = 0; g < NPH; g++) begin : g_oh
    assign onehot_o[g] = (phase_i == phase_e'(3'(g)));
  end

  logic in_mem;
  assign in_mem     = (phase_i == PH_MEMORY);
  assign br_taken_o = (phase_i == PH_DECODE) && (kind_i == K_BRANCH) && cmp_eq_i;
  assign ir_we_o    = (phase_i == PH_FETCH);
  assign pc_we_o    = ir_we_o || br_taken_o;
  assign pc_sel_o   = br_taken_o;
  assign rf_we_o    = (phase_i == PH_WRBACK) && writes_reg(kind_i);
  assign mem_rd_o   = in_mem && (kind_i == K_LOAD);
  assign mem_wr_o   = in_mem && (kind_i == K_STORE);
endmodule

// File: rtl/mseq_pc_unit.sv
module mseq_pc_unit
  import mseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pc_we_i,
  input  logic               pc_sel_i,
  input  logic               ir_we_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [INSTR_W-1:0] ir_o
);
  logic [ADDR_W-1:0]  pc_q;
  logic [INSTR_W-1:0] ir_q;
  logic [ADDR_W-1:0]  pc_seq;
  logic [ADDR_W-1:0]  pc_tgt;

  assign pc_seq = seq_next(pc_q);
  assign pc_tgt = branch_dest(pc_q, ir_q[OFF_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (pc_we_i) pc_q <= pc_sel_i ? pc_tgt : pc_seq;
      if (ir_we_i) ir_q <= instr_i;
    end
  end

  assign pc_o = pc_q;
  assign ir_o = ir_q;
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [CODE_W-1:0]  cls_i,
  input  logic               cmp_eq_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic [NPH-1:0]     phase_o,
  output logic               pc_we_o,
  output logic               pc_sel_o,
  output logic               rf_we_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               done_o
);
  phase_e phase;
  kind_e  kind_eff;
  logic   last;
  logic   pc_we;
  logic   pc_sel;
  logic   ir_we;
  logic   br_taken;

  mseq_phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .code_i     (cls_i),
    .phase_o    (phase),
    .kind_eff_o (kind_eff),
    .last_o     (last)
  );

  mseq_strobes u_strb (
    .phase_i    (phase),
    .kind_i     (kind_eff),
    .cmp_eq_i   (cmp_eq_i),
    .onehot_o   (phase_o),
    .pc_we_o    (pc_we),
    .pc_sel_o   (pc_sel),
    .ir_we_o    (ir_we),
    .rf_we_o    (rf_we_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .br_taken_o (br_taken)
  );

  mseq_pc_unit u_pc (
    .clk      (clk),
    .rst      (rst),
    .pc_we_i  (pc_we),
    .pc_sel_i (pc_sel),
    .ir_we_i  (ir_we),
    .instr_i  (instr_i),
    .pc_o     (pc_o),
    .ir_o     (ir_o)
  );

  assign pc_we_o  = pc_we;
  assign pc_sel_o = pc_sel;
  assign done_o   = last;
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker
  import mseq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NPH-1:0]    phase_oh,
  input logic [ADDR_W-1:0] pc,
  input logic              pc_we,
  input logic              pc_sel,
  input logic              rf_we,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              done,
  input logic              br_taken
);
  assert_onehot_phase_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh) == 1);

  assert_fetch_step_R3: assert property (@(posedge clk) disable iff (rst)
    phase_oh[0] |=> pc == $past(pc) + ADDR_W'(STEP));

  assert_taken_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (pc_we && pc_sel) |-> (phase_oh[1] && done));

  assert_taken_flag_R4: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> phase_oh[0]);

  assert_store_final_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> done);

  assert_load_continues_R6: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (phase_oh[4] && rf_we));

  assert_wb_final_R7: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (phase_oh[4] && done));

  assert_done_to_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> phase_oh[0]);

  assert_mem_phase_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> phase_oh[3]);

  assert_mem_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

bind mseq_ctrl mseq_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .phase_oh (phase_o),
  .pc       (pc_o),
  .pc_we    (pc_we_o),
  .pc_sel   (pc_sel_o),
  .rf_we    (rf_we_o),
  .mem_rd   (mem_rd_o),
  .mem_wr   (mem_wr_o),
  .done     (done_o),
  .br_taken (br_taken)
);

// File: tb/tb_mseq_ctrl.sv
module tb_mseq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_i = '0;
  logic [2:0]  cls_i = '0;
  logic        cmp_eq_i = 1'b0;
  logic [31:0] pc_o, ir_o;
  logic [4:0]  phase_o;
  logic        pc_we_o, pc_sel_o, rf_we_o, mem_rd_o, mem_wr_o, done_o;

  mseq_ctrl dut (
    .clk(clk), .rst(rst), .instr_i(instr_i), .cls_i(cls_i), .cmp_eq_i(cmp_eq_i),
    .pc_o(pc_o), .ir_o(ir_o), .phase_o(phase_o), .pc_we_o(pc_we_o),
    .pc_sel_o(pc_sel_o), .rf_we_o(rf_we_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [2:0]  c;
    bit          eq;
    logic [31:0] start;
    logic [31:0] word;
    int          n;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] pc_m = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] norm(input logic [2:0] c);
    return (c > 3'd4) ? 3'd0 : c;
  endfunction

  // driver: called at a negedge where the design is in fetch
  task automatic run(input logic [2:0] c, input bit eq, input logic [15:0] off, input bit scramble);
    exp_t e;
    logic [31:0] ext;
    e.c = norm(c);
    e.eq = eq;
    e.start = pc_m;
    e.word = {16'h5A5A, off};
    e.n = (e.c == 3'd4) ? 2 : (e.c == 3'd3) ? 4 : 5;
    ext = {{16{off[15]}}, off};
    pc_m = pc_m + 32'd4;
    if (e.c == 3'd4 && eq) pc_m = pc_m + (ext << 2);
    sb.push_back(e);
    instr_i = e.word;
    cls_i = c;
    cmp_eq_i = eq;
    @(negedge clk);
    instr_i = ~e.word;
    for (int i = 1; i < e.n; i++) begin
      @(negedge clk);
      if (scramble) begin
        cls_i = (e.c == 3'd4) ? 3'd2 : 3'd4;
        cmp_eq_i = ~eq;
      end
    end
  endtask

  // monitor: scoreboard compare a quarter period after each negedge
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rst) k = 0;
      else if (sb.size() > 0) begin
        exp_t e;
        bit tk;
        e = sb[0];
        tk = (k == 1) && (e.c == 3'd4) && e.eq;
        chk("R2", "phase", {27'd0, phase_o}, 32'd1 << k);
        chk(k == 0 ? "R3" : "R4", "pc", pc_o, (k == 0) ? e.start : e.start + 32'd4);
        if (k >= 1) chk("R3", "ir", ir_o, e.word);
        chk(e.c == 3'd4 ? "R4" : "R3", "pc_we", {31'd0, pc_we_o}, {31'd0, (k == 0) || tk});
        chk("R4", "pc_sel", {31'd0, pc_sel_o}, {31'd0, tk});
        chk(e.c == 3'd3 ? "R5" : "R10", "mem_wr", {31'd0, mem_wr_o}, {31'd0, (k == 3) && (e.c == 3'd3)});
        chk(e.c == 3'd2 ? "R6" : "R10", "mem_rd", {31'd0, mem_rd_o}, {31'd0, (k == 3) && (e.c == 3'd2)});
        chk(e.c == 3'd2 ? "R6" : "R7", "rf_we", {31'd0, rf_we_o},
            {31'd0, (k == 4) && (e.c != 3'd3) && (e.c != 3'd4)});
        chk("R8", "done", {31'd0, done_o}, {31'd0, k == e.n - 1});
        if (k == e.n - 1) begin
          void'(sb.pop_front());
          k = 0;
        end else k++;
      end
    end
  end

  task automatic reset_check(input string tag);
    chk("R1", {tag, " phase"}, {27'd0, phase_o}, 32'd1);
    chk("R1", {tag, " pc"}, pc_o, 32'd0);
  endtask

  task automatic main;
    repeat (3) @(negedge clk);
    reset_check("initial");
    rst = 1'b0;
    pc_m = '0;
    run(3'd0, 1'b0, 16'h0010, 1'b0);        // R7 ALU reg-reg
    run(3'd1, 1'b1, 16'h0020, 1'b0);        // R7 ALU immediate
    run(3'd2, 1'b0, 16'h0004, 1'b0);        // R6 load
    run(3'd3, 1'b0, 16'h0008, 1'b0);        // R5 store
    run(3'd4, 1'b0, 16'h0040, 1'b0);        // R4 branch not taken
    run(3'd4, 1'b1, 16'h0003, 1'b0);        // R4 taken, positive offset
    run(3'd4, 1'b1, 16'hFFFE, 1'b0);        // R4 taken, negative offset
    run(3'd4, 1'b1, 16'h8000, 1'b0);        // R4 most negative offset
    run(3'd4, 1'b1, 16'h7FFF, 1'b0);        // R4 most positive offset
    run(3'd6, 1'b1, 16'h0001, 1'b0);        // R7 unassigned code
    run(3'd5, 1'b0, 16'h0001, 1'b0);        // R7 unassigned code
    run(3'd2, 1'b1, 16'h0002, 1'b1);        // R9 load, class changed after decode
    run(3'd3, 1'b1, 16'h0002, 1'b1);        // R9 store, class changed after decode
    run(3'd4, 1'b0, 16'h0005, 1'b1);        // R9 branch, compare toggled afterwards
    run(3'd1, 1'b0, 16'h0000, 1'b0);
    chk("R8", "scoreboard drained", sb.size(), 32'd0);
    // R1: reset in the middle of a load
    instr_i = 32'h0000_0100;
    cls_i = 3'd2;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    reset_check("mid-instruction");
    rst = 1'b0;
    pc_m = '0;
    run(3'd3, 1'b0, 16'h0001, 1'b0);        // R1 restart from fetch at 0
    run(3'd4, 1'b1, 16'h0010, 1'b0);
    chk("R8", "scoreboard drained", sb.size(), 32'd0);
  endtask

  initial begin
    fork
      main();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule